// File: doc/BRIEF.md
# Serial Configuration Bitstream Receiver

This block receives a configuration bitstream one bit per rising edge of the configuration clock. A fixed 16-bit preamble opens the stream, and the block checks it bit by bit. A 24-bit length count follows, sent most significant bit first, and the block captures it. The block then counts configuration clocks and raises a completion output once the number of clocks received since reset reaches the length count. Payload bits after the header are counted but not stored.

Every incoming bit is also passed to a daisy-chain output one clock later, so a downstream receiver sees the same stream, header included. A status output stays high while loading is healthy. A preamble mismatch drops it low and sets a sticky error flag. A synchronous active-low reset restarts the whole process.

Top module: `cfg_stream_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `cfg_done` to 0, `chain_out` to 0 and `hdr_err` to 0, sets `load_ok` to 1, and clears the clock count and the captured length.
- R2: After clock edge k, `chain_out` equals the bit presented on `din` at edge k. This is a one-clock delay and applies to every bit, including the 40 header bits.
- R3: Bits 1 to 16 after reset must equal 0xFF20, most significant bit first. If bit p (1 ≤ p ≤ 16) differs, then after edge p `hdr_err` is 1 and `load_ok` is 0.
- R4: A preamble error is sticky until reset, and `cfg_done` never rises while it is set.
- R5: Bits 17 to 40 form the 24-bit length count L, most significant bit first. After bit 40 the captured value no longer changes.
- R6: The clock count includes the header, starting from the first preamble bit. With a valid preamble and L ≥ 40, `cfg_done` is 0 after edges 1 to L−1 and 1 after edge L.
- R7: With a valid preamble and L ≤ 40, `cfg_done` rises after edge 40, the same edge that completes the header.
- R8: Once `cfg_done` is high, further clocks with any data are accepted and `cfg_done` stays high until reset.
- R9: A reset applied after completion returns the outputs to the R1 state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; one stream bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Serial stream data in |
| chain_out | output | 1 | Stream data repeated one clock later for the next device |
| cfg_done | output | 1 | High once the clock count reaches the length count |
| load_ok | output | 1 | High while loading is healthy; low after a preamble error |
| hdr_err | output | 1 | Sticky preamble mismatch flag |

## Verification
Two things can happen on the same edge: the last length bit is captured, and completion is declared. This occurs whenever the length count is 40 or less, because the header itself already brings the clock count to 40. The bench sweeps every length from 0 to 48, which covers short lengths, the exact boundary and a few values just above it. It also runs several large lengths. After each edge the bench compares `cfg_done` against the arithmetic expectation `k >= max(L,40)`, and the chained bit and status outputs against the expected stream. Each of the 16 preamble positions is also corrupted in turn, to confirm that completion is suppressed at every position.

// File: rtl/cfg_rx_pkg.sv
// Package: shared widths and constants for the serial configuration receiver.
// Assumes the header is a fixed preamble followed directly by the length field.
package cfg_rx_pkg;
    localparam int unsigned PRE_W     = 16;
    localparam logic [PRE_W-1:0] PREAMBLE = 16'hFF20;
    localparam int unsigned LEN_W     = 24;
    localparam int unsigned HDR_W     = PRE_W + LEN_W;
    localparam int unsigned HDR_IDX_W = $clog2(HDR_W + 1);

    // Header parser phase.
    typedef enum logic [1:0] {
        PH_PREAMBLE = 2'd0,
        PH_LENGTH   = 2'd1,
        PH_PAYLOAD  = 2'd2
    } hdr_phase_e;
endpackage

// File: rtl/cfg_hdr_parser.sv
// Module: cfg_hdr_parser
// Checks the preamble bit by bit and shifts in the length count, MSB first.
// Assumes one stream bit per clock starting with the first edge after reset.
// Outputs: captured length, header-complete flag, sticky preamble error.
module cfg_hdr_parser
    import cfg_rx_pkg::*;
#(
    parameter int unsigned P_PRE_W = PRE_W,
    parameter logic [P_PRE_W-1:0] P_PREAMBLE = PREAMBLE,
    parameter int unsigned P_LEN_W = LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    output logic [P_LEN_W-1:0] len_q,
    output logic               hdr_done,
    output logic               pre_err
);
    localparam int unsigned TOT_W = P_PRE_W + P_LEN_W;
    localparam int unsigned CW    = $clog2(TOT_W + 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(P_PRE_W - 1);
    localparam logic [CW-1:0] HDR_LAST = CW'(TOT_W - 1);

    hdr_phase_e           phase_q;
    logic [CW-1:0]        idx_q;
    logic [P_PRE_W-1:0]   expect_sr;
    logic                 err_q;

    // Advance the header phase and bit index for every received bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PREAMBLE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_PREAMBLE: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == PRE_LAST) phase_q <= PH_LENGTH;
                end
                PH_LENGTH: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == HDR_LAST) phase_q <= PH_PAYLOAD;
                end
                default: begin
                    phase_q <= PH_PAYLOAD;
                end
            endcase
        end
    end

    // Shift the expected preamble so its MSB is the bit due this clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_sr <= P_PREAMBLE;
        end else if (phase_q == PH_PREAMBLE) begin
            expect_sr <= {expect_sr[P_PRE_W-2:0], 1'b0};
        end
    end

    // Record a sticky error on the first preamble mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (phase_q == PH_PREAMBLE && bit_in != expect_sr[P_PRE_W-1]) begin
            err_q <= 1'b1;
        end
    end

    // Shift the length field in, MSB first, during the length phase only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (phase_q == PH_LENGTH) begin
            len_q <= {len_q[P_LEN_W-2:0], bit_in};
        end
    end

    assign hdr_done = (phase_q == PH_PAYLOAD);
    assign pre_err  = err_q;

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_err |=> pre_err);
    // R5
    len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> (hdr_done && $stable(len_q)));
    // R3
    preamble_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_err && hdr_done) |=> !pre_err);
endmodule

// File: rtl/cfg_clk_counter.sv
// Module: cfg_clk_counter
// Counts configuration clocks since reset, header included, saturating at
// all-ones so an oversized length never wraps. Declares completion when the
// header is valid and the count has reached the captured length.
module cfg_clk_counter #(
    parameter int unsigned P_LEN_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_LEN_W-1:0] len_cnt,
    input  logic               hdr_ok,
    output logic [P_LEN_W-1:0] clk_cnt,
    output logic               done
);
    localparam logic [P_LEN_W-1:0] CNT_MAX = {P_LEN_W{1'b1}};

    logic [P_LEN_W-1:0] cnt_q;
    logic               reached;

    // Count every clock after reset, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare the running count against the captured length.
    always_comb begin
        reached = (cnt_q >= len_cnt);
    end

    assign clk_cnt = cnt_q;
    assign done    = hdr_ok & reached;

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) |=> (cnt_q == P_LEN_W'($past(cnt_q) + 1'b1)));
    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/cfg_chain_out.sv
// Module: cfg_chain_out
// Repeats the incoming stream on the daisy-chain output after DLY clocks.
// Assumes DLY >= 1; the stages are cleared by reset.
module cfg_chain_out #(
    parameter int unsigned DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);
    logic [DLY-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < DLY; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the live input bit.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= bit_in;
                end
            end else begin : g_next
                // Pass the bit along one more clock.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign bit_out = stage_q[DLY-1];

    // R2
    chain_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DLY == 1) |=> (bit_out == $past(bit_in)));
endmodule

// File: rtl/cfg_stream_rx.sv
// Module: cfg_stream_rx (top)
// Serial configuration bitstream receiver: preamble check, length capture,
// clock counting to completion and daisy-chain repeat of every bit.
// Assumes one bit per rising edge of cclk, starting with the first edge
// after rst_n is released.
module cfg_stream_rx
    import cfg_rx_pkg::*;
#(
    parameter int unsigned CHAIN_DLY = 1
) (
    input  logic cclk,
    input  logic rst_n,
    input  logic din,
    output logic chain_out,
    output logic cfg_done,
    output logic load_ok,
    output logic hdr_err
);
    logic [LEN_W-1:0] len_w;
    logic [LEN_W-1:0] cnt_w;
    logic             hdr_done_w;
    logic             pre_err_w;
    logic             hdr_ok_w;
    logic             done_w;

    cfg_hdr_parser #(
        .P_PRE_W    (PRE_W),
        .P_PREAMBLE (PREAMBLE),
        .P_LEN_W    (LEN_W)
    ) u_parser (
        .clk      (cclk),
        .rst_n    (rst_n),
        .bit_in   (din),
        .len_q    (len_w),
        .hdr_done (hdr_done_w),
        .pre_err  (pre_err_w)
    );

    // Header counts as valid only once complete and free of errors.
    always_comb begin
        hdr_ok_w = hdr_done_w & ~pre_err_w;
    end

    cfg_clk_counter #(
        .P_LEN_W (LEN_W)
    ) u_counter (
        .clk     (cclk),
        .rst_n   (rst_n),
        .len_cnt (len_w),
        .hdr_ok  (hdr_ok_w),
        .clk_cnt (cnt_w),
        .done    (done_w)
    );

    cfg_chain_out #(
        .DLY (CHAIN_DLY)
    ) u_chain (
        .clk     (cclk),
        .rst_n   (rst_n),
        .bit_in  (din),
        .bit_out (chain_out)
    );

    assign cfg_done = done_w;
    assign hdr_err  = pre_err_w;
    assign load_ok  = ~pre_err_w;

    // R8
    done_sticky_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        cfg_done |=> cfg_done);
    // R4
    done_no_err_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        cfg_done |-> !hdr_err);
    // R7
    done_after_hdr_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        cfg_done |-> (cnt_w >= LEN_W'(HDR_W)));
    // R6
    done_count_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        cfg_done |-> (cnt_w >= len_w));
endmodule

// File: tb/test_cfg_stream_rx.sv
module test_cfg_stream_rx;
    logic cclk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic chain_out, cfg_done, load_ok, hdr_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 cclk = ~cclk;  // 200 MHz

    cfg_stream_rx i_cfg_stream_rx (
        .cclk(cclk), .rst_n(rst_n), .din(din),
        .chain_out(chain_out), .cfg_done(cfg_done),
        .load_ok(load_ok), .hdr_err(hdr_err)
    );

    task automatic chk(input string req, input logic act, input logic exp, input int k, input int len);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s edge=%0d L=%0d actual=%0b expected=%0b", req, k, len, act, exp);
        end
    endtask

    // Stream bit k (1-based): preamble, length MSB first, then a payload pattern.
    function automatic logic sbit(input int k, input int len);
        logic [15:0] pre = 16'hFF20;
        logic [23:0] lv = 24'(len);
        if (k <= 16) return pre[16-k];
        if (k <= 40) return lv[40-k];
        return ((k * 5) % 7) < 3;
    endfunction

    // One stream: reset, feed bits, flip preamble bit p (0 = none), extra clocks.
    task automatic run(input int len, input int p, input int extra);
        int thr = (len > 40) ? len : 40;
        int n = thr + extra;
        @(negedge cclk);
        rst_n = 1'b0; din = 1'b0;
        repeat (2) @(posedge cclk);
        @(negedge cclk);
        chk("R1 done", cfg_done, 1'b0, 0, len);
        chk("R1 load_ok", load_ok, 1'b1, 0, len);
        chk("R1 hdr_err", hdr_err, 1'b0, 0, len);
        chk("R1 chain", chain_out, 1'b0, 0, len);
        for (int k = 1; k <= n; k++) begin
            logic b = sbit(k, len);
            logic e;
            if (k == p) b = ~b;
            din = b; rst_n = 1'b1;
            @(posedge cclk);
            @(negedge cclk);
            e = (p != 0) && (k >= p);
            chk("R2 chain", chain_out, b, k, len);
            chk("R3 hdr_err", hdr_err, e, k, len);
            chk("R3 load_ok", load_ok, ~e, k, len);
            if (e) chk("R4 done", cfg_done, 1'b0, k, len);
            else if (k > thr) chk("R8 done", cfg_done, 1'b1, k, len);
            else if (len <= 40) chk("R7 done", cfg_done, k >= 40, k, len);
            else chk("R6 R5 done", cfg_done, k >= len, k, len);
        end
        // R9: reset after the run clears everything.
        rst_n = 1'b0; din = 1'b1;
        @(posedge cclk);
        @(negedge cclk);
        chk("R9 done", cfg_done, 1'b0, -1, len);
        chk("R9 load_ok", load_ok, 1'b1, -1, len);
        chk("R9 hdr_err", hdr_err, 1'b0, -1, len);
        chk("R9 chain", chain_out, 1'b0, -1, len);
    endtask

    initial begin
        for (int l = 0; l <= 48; l++) run(l, 0, 6);
        run(200, 0, 20);
        run(1000, 0, 10);
        run(4097, 0, 10);
        for (int q = 1; q <= 16; q++) run(50, q, 5);
        run(20, 16, 30);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge cclk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule